// File: doc/BRIEF.md
# Burst Cache Line Fill Controller

This controller fills one cache line after a read miss. The cache side presents a miss request with the byte address of the missed long word. The controller then runs a series of synchronous bus beats and raises a burst request so that the slave can return the whole line. Each beat ends when the slave asserts the synchronous termination input. The first beat always fetches the missed word. The later beats step through the line's word index modulo the line size, so the addresses stay inside one line and suit page-mode, static-column and nibble-mode memories.

The slave accepts the burst by asserting the acknowledge input together with the first termination. Without it, the controller keeps the single word and ends the fill. A bus error on any beat stops the fill. The controller then invalidates the partly written line and reports the error. Each returned word goes to the line write port together with its entry index. A registered mask records which entries of the current fill hold valid data.

The states are IDLE, FIRST (first beat), BURST (beats two to four), FINISH (one-cycle completion pulse) and FAIL (one-cycle error and invalidate pulse). The transitions are:

- IDLE→FIRST on an accepted miss.
- FIRST→BURST on a clean termination with acknowledge.
- FIRST→FINISH on a clean termination without acknowledge.
- BURST→BURST on a clean termination that is not the last.
- BURST→FINISH on the last clean termination.
- FIRST/BURST→FAIL on a bus error.
- FINISH→IDLE and FAIL→IDLE always.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset the controller is idle. busy, bus_cyc, burst_req, lw_en, fill_done, fill_err and line_inval are 0, fill_mask is 0 and bus_addr is 0.
- R2: A miss_req sampled high in IDLE starts a fill. From the next cycle bus_cyc is 1 and bus_addr holds the missed word's address with its two low bits at 0. A miss_req while busy is ignored.
- R3: A beat completes only in a cycle with bus_cyc, sterm and no berr. In that same cycle lw_en is 1, lw_idx is the entry index and lw_data equals bus_data. Cycles without sterm are wait states that repeat the beat.
- R4: burst_ack is sampled only with the first beat's termination. If it is 0, only that entry is written and the fill finishes.
- R5: After the first beat, each beat's entry index is the previous index plus 1 modulo 4. bus_addr bits [3:2] carry the index and the upper bits stay constant.
- R6: burst_req is 1 during the first beat and during the second and third burst beats. It is 0 during the fourth beat and outside fills.
- R7: The cycle after the last completed beat, fill_done is 1 for exactly one cycle with busy still 1. busy is 0 in the following cycle.
- R8: berr during a beat, with or without sterm, writes nothing. In the next cycle fill_err and line_inval are 1 for one cycle, and fill_mask is 0 in the cycle after that.
- R9: fill_mask bit i becomes 1 the cycle after entry i is written. The mask is cleared the cycle after a new miss is accepted.
- R10: sterm, berr and burst_ack while idle have no effect. lw_en stays 0 and fill_mask is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Cache miss request |
| miss_addr | input | 32 | Byte address of missed word |
| busy | output | 1 | Fill in progress |
| fill_done | output | 1 | Fill completed pulse |
| fill_err | output | 1 | Fill aborted by bus error pulse |
| bus_cyc | output | 1 | Bus beat active |
| bus_addr | output | 32 | Beat address |
| burst_req | output | 1 | Burst request to slave |
| burst_ack | input | 1 | Slave accepts burst |
| sterm | input | 1 | Synchronous beat termination |
| berr | input | 1 | Bus error |
| bus_data | input | 32 | Read data |
| lw_en | output | 1 | Line entry write enable |
| lw_idx | output | 2 | Line entry index |
| lw_data | output | 32 | Line entry data |
| line_inval | output | 1 | Invalidate current line pulse |
| fill_mask | output | 4 | Entries valid in current fill |

## Verification
The beat outputs bus_cyc, bus_addr, burst_req and the write port are due one cycle after the miss is accepted. The write strobe follows sterm in the same cycle. fill_done, fill_err and line_inval are due one cycle after the terminating beat, and fill_mask changes one cycle after the write it records. The bench drives every input on the falling edge. One nanosecond later it compares all outputs with a behavioural model whose state advances only at the rising edge, so each result is checked in exactly the cycle the requirements give.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_FIRST  = 3'd1,
        S_BURST  = 3'd2,
        S_FINISH = 3'd3,
        S_FAIL   = 3'd4
    } fill_state_e;
endpackage

// File: rtl/lfc_beat_ctr.sv
module lfc_beat_ctr #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            idx   <= load_idx;
            cnt_q <= '0;
        end else if (step) begin
            idx   <= idx + 1'b1;   // wraps inside the line
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == IDX_W'(BEATS - 1));
endmodule

// File: rtl/lfc_fill_mask.sv
module lfc_fill_mask #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [BEATS-1:0] mask
);
    for (genvar g = 0; g < BEATS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                mask[g] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(g))
                mask[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
    import lfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int BASE_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              busy,
    output logic              fill_done,
    output logic              fill_err,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              burst_req,
    input  logic              burst_ack,
    input  logic              sterm,
    input  logic              berr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              lw_en,
    output logic [IDX_W-1:0]  lw_idx,
    output logic [DATA_W-1:0] lw_data,
    output logic              line_inval,
    output logic [BEATS-1:0]  fill_mask
);
    fill_state_e      state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic              accept, in_beat, beat_ok, beat_err;

    assign accept   = (state_q == S_IDLE) && miss_req;
    assign in_beat  = (state_q == S_FIRST) || (state_q == S_BURST);
    assign beat_err = in_beat && berr;
    assign beat_ok  = in_beat && sterm && !berr;

    lfc_beat_ctr #(.BEATS(BEATS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_idx (miss_addr[OFF_W +: IDX_W]),
        .step     (beat_ok),
        .idx      (idx),
        .last     (last)
    );

    lfc_fill_mask #(.BEATS(BEATS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept || state_q == S_FAIL),
        .set_en  (beat_ok),
        .set_idx (idx),
        .mask    (fill_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (accept)
            base_q <= miss_addr[ADDR_W-1 -: BASE_W];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (miss_req) state_d = S_FIRST;
            S_FIRST: begin
                if (beat_err)     state_d = S_FAIL;
                else if (beat_ok) state_d = burst_ack ? S_BURST : S_FINISH;
            end
            S_BURST: begin
                if (beat_err)             state_d = S_FAIL;
                else if (beat_ok && last) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            S_FAIL:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        fill_done  = 1'b0;
        fill_err   = 1'b0;
        line_inval = 1'b0;
        bus_cyc    = 1'b0;
        burst_req  = 1'b0;
        bus_addr   = '0;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_FIRST: begin
                bus_cyc   = 1'b1;
                burst_req = (BEATS > 1);
                bus_addr  = {base_q, idx, {OFF_W{1'b0}}};
            end
            S_BURST: begin
                bus_cyc   = 1'b1;
                burst_req = !last;
                bus_addr  = {base_q, idx, {OFF_W{1'b0}}};
            end
            S_FINISH: fill_done = 1'b1;
            S_FAIL: begin
                fill_err   = 1'b1;
                line_inval = 1'b1;
            end
            default:  busy = 1'b0;
        endcase
    end

    assign lw_en   = beat_ok;
    assign lw_idx  = idx;
    assign lw_data = bus_data;
endmodule

// File: rtl/line_fill_ctrl_chk.sv
module line_fill_ctrl_chk #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             fill_done,
    input logic             fill_err,
    input logic             bus_cyc,
    input logic             burst_req,
    input logic             lw_en,
    input logic [IDX_W-1:0] lw_idx,
    input logic             line_inval,
    input logic [BEATS-1:0] fill_mask
);
    a_r6_req_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> bus_cyc);
    a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !busy);
    a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        line_inval |=> (fill_mask == '0));
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_done, fill_err, bus_cyc}));
    a_r5_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en && $past(lw_en)) |-> (lw_idx == $past(lw_idx) + 1'b1));
    a_r9_mask_records: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en |=> fill_mask[$past(lw_idx)]);
endmodule

bind line_fill_ctrl line_fill_ctrl_chk #(.BEATS(BEATS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .fill_done  (fill_done),
    .fill_err   (fill_err),
    .bus_cyc    (bus_cyc),
    .burst_req  (burst_req),
    .lw_en      (lw_en),
    .lw_idx     (lw_idx),
    .line_inval (line_inval),
    .fill_mask  (fill_mask)
);

// File: tb/line_fill_ctrl_tb.sv
module line_fill_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_req = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        busy, fill_done, fill_err, bus_cyc, burst_req;
    logic [31:0] bus_addr;
    logic        burst_ack = 1'b0, sterm = 1'b0, berr = 1'b0;
    logic [31:0] bus_data = '0;
    logic        lw_en, line_inval;
    logic [1:0]  lw_idx;
    logic [31:0] lw_data;
    logic [3:0]  fill_mask;

    int tests = 0, fails = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 first, 2 burst, 3 finish, 4 fail
    int m_state = 0, m_idx = 0, m_cnt = 0, m_mask = 0;
    longint m_base = 0;

    always #2 clk = ~clk;

    line_fill_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
        .busy(busy), .fill_done(fill_done), .fill_err(fill_err),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .burst_req(burst_req),
        .burst_ack(burst_ack), .sterm(sterm), .berr(berr), .bus_data(bus_data),
        .lw_en(lw_en), .lw_idx(lw_idx), .lw_data(lw_data),
        .line_inval(line_inval), .fill_mask(fill_mask)
    );

    task automatic chk(string req, string scen, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, scen, act, exp);
        end
    endtask

    task automatic compare(string scen);
        bit cyc, we;
        cyc = (m_state == 1 || m_state == 2);
        we  = cyc && sterm && !berr;
        chk("R7 busy", scen, busy, m_state != 0);
        chk("R7 fill_done", scen, fill_done, m_state == 3);
        chk("R8 fill_err", scen, fill_err, m_state == 4);
        chk("R8 line_inval", scen, line_inval, m_state == 4);
        chk("R2 bus_cyc", scen, bus_cyc, cyc);
        chk("R5 bus_addr", scen, bus_addr, cyc ? ((m_base << 4) | longint'(m_idx << 2)) : 0);
        chk("R6 burst_req", scen, burst_req, m_state == 1 || (m_state == 2 && m_cnt != 3));
        chk("R3 lw_en", scen, lw_en, we);
        if (we) begin
            chk("R3 lw_idx", scen, lw_idx, m_idx);
            chk("R3 lw_data", scen, lw_data, bus_data);
        end
        chk("R9 fill_mask", scen, fill_mask, m_mask);
    endtask

    task automatic advance();
        case (m_state)
            0: if (miss_req) begin
                m_state = 1; m_base = longint'(miss_addr >> 4);
                m_idx = int'(miss_addr[3:2]); m_cnt = 0; m_mask = 0;
            end
            1: if (berr) m_state = 4;
               else if (sterm) begin
                   m_mask |= (1 << m_idx);
                   if (burst_ack) begin m_state = 2; m_idx = (m_idx + 1) % 4; m_cnt = 1; end
                   else m_state = 3;
               end
            2: if (berr) m_state = 4;
               else if (sterm) begin
                   m_mask |= (1 << m_idx);
                   if (m_cnt == 3) m_state = 3;
                   else begin m_cnt++; m_idx = (m_idx + 1) % 4; end
               end
            3: m_state = 0;
            4: begin m_state = 0; m_mask = 0; end
            default: m_state = 0;
        endcase
    endtask

    task automatic cyc(bit mr, logic [31:0] ma, bit st, bit ak, bit be, logic [31:0] d, string scen);
        @(negedge clk);
        miss_req = mr; miss_addr = ma; sterm = st; burst_ack = ak; berr = be; bus_data = d;
        #1 compare(scen);
        @(posedge clk);
        advance();
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 compare("R1 reset");
        rst_n = 1'b1;
        // R10: terminations while idle do nothing
        cyc(0, 0, 1, 1, 0, 32'h11, "R10 idle sterm");
        cyc(0, 0, 1, 0, 1, 32'h12, "R10 idle berr");
        // full burst starting at index 2, with wait states (R2 R3 R5 R6 R7 R9)
        cyc(1, 32'h1000_0028, 0, 0, 0, 0, "R2 accept");
        cyc(0, 0, 0, 0, 0, 0, "R3 wait");
        cyc(0, 0, 1, 1, 0, 32'hA0A0_0002, "R5 beat1");
        cyc(1, 32'h2000_0000, 1, 0, 0, 32'hA0A0_0003, "R2 miss ignored busy");
        cyc(0, 0, 0, 0, 0, 0, "R3 wait2");
        cyc(0, 0, 1, 0, 0, 32'hA0A0_0000, "R5 beat3");
        cyc(0, 0, 1, 0, 0, 32'hA0A0_0001, "R6 final beat");
        cyc(0, 0, 0, 0, 0, 0, "R7 done");
        cyc(0, 0, 0, 0, 0, 0, "R7 idle");
        cyc(0, 0, 1, 0, 0, 32'h5, "R10 mask kept");
        // no acknowledge: single word (R4)
        cyc(1, 32'h3000_003C, 0, 0, 0, 0, "R4 accept");
        cyc(0, 0, 1, 0, 0, 32'hBEEF_0003, "R4 single");
        cyc(0, 0, 0, 0, 0, 0, "R4 done");
        cyc(0, 0, 0, 0, 0, 0, "R4 idle");
        // bus error on third beat (R8)
        cyc(1, 32'h4000_0010, 0, 0, 0, 0, "R8 accept");
        cyc(0, 0, 1, 1, 0, 32'hC0, "R8 beat1");
        cyc(0, 0, 1, 0, 0, 32'hC1, "R8 beat2");
        cyc(0, 0, 1, 0, 1, 32'hC2, "R8 err with sterm");
        cyc(0, 0, 0, 0, 0, 0, "R8 fail pulse");
        cyc(0, 0, 0, 0, 0, 0, "R8 mask cleared");
        // bus error on first beat, no sterm
        cyc(1, 32'h5000_0004, 0, 0, 0, 0, "R8 accept2");
        cyc(0, 0, 0, 0, 1, 32'hD0, "R8 err first");
        cyc(0, 0, 0, 0, 0, 0, "R8 fail2");
        cyc(0, 0, 0, 0, 0, 0, "R8 idle2");
        // back-to-back full burst from index 3, mask cleared on accept
        cyc(1, 32'h6000_00FC, 0, 0, 0, 0, "R9 accept");
        cyc(0, 0, 1, 1, 0, 32'hE3, "R5 wrap b1");
        cyc(0, 0, 1, 0, 0, 32'hE0, "R5 wrap b2");
        cyc(0, 0, 1, 0, 0, 32'hE1, "R5 wrap b3");
        cyc(0, 0, 1, 0, 0, 32'hE2, "R6 wrap b4");
        cyc(0, 0, 0, 0, 0, 0, "R7 done2");
        cyc(0, 0, 0, 0, 0, 0, "R7 idle2");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule